// File: doc/BRIEF.md
# Single-Cycle Integer Instruction Core

This block is a minimal processor core that completes one instruction per clock cycle. On every cycle it presents the program counter to an external instruction memory. That memory answers combinationally in the same cycle. The core then splits the returned word into fields, reads two source registers and runs the arithmetic or logic operation. On the next rising edge it writes the result back and moves the program counter on by four bytes.

Three operations are supported. Two are register-register operations: unsigned add and unsigned subtract. The third is an OR with a 16-bit immediate. The register-register and immediate forms share one datapath. A destination multiplexer picks the write register, and an operand multiplexer picks the second ALU input. The immediate extender can zero-extend or sign-extend, under control of the decoder.

A third, independent read port on the register file lets a testbench or debugger observe any register combinationally.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high on a rising edge, the program counter becomes 0 and every register becomes 0; after reset, `imem_addr` reads 0 until the next edge.
- R2: On every rising edge without reset, `imem_addr` increases by 4 (modulo 2^32), whatever instruction was executed.
- R3: An instruction with opcode bits [31:26] = 0, bits [10:6] = 0 and function bits [5:0] = 0x21 writes register rd (bits [15:11]) with the sum of registers rs (bits [25:21]) and rt (bits [20:16]), modulo 2^32 and with no overflow detection.
- R4: The same format with function bits 0x23 writes rd with rs minus rt, modulo 2^32 and with no overflow detection.
- R5: Opcode 0x0D writes register rt with rs OR the zero-extended value of bits [15:0]. The register named by bits [15:11] is not written, and the value read from rt does not affect the result.
- R6: Register 0 always reads as 0, and any write aimed at it is discarded.
- R7: Any other opcode, any opcode-0 word whose function is neither 0x21 nor 0x23, and any opcode-0 word with nonzero bits [10:6] writes no register.
- R8: Source reads see the register contents from before the current instruction. The result is visible from the next cycle on, so an instruction whose destination is also its source uses the old value.
- R9: `dbg_data` shows the current content of register `dbg_addr` combinationally, and the debug port has no effect on execution.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction being executed (program counter) |
| imem_data | input | 32 | Instruction word returned combinationally for `imem_addr` |
| dbg_addr | input | 5 | Register index for the debug read port |
| dbg_data | output | 32 | Content of the register selected by `dbg_addr` |

## Verification
The hardest situations to reach are the quiet ones. A write aimed at register 0 must leave no trace. An immediate OR must not touch the register its bit [15:11] field happens to name. An undecodable word must change nothing. None of these shows at any output unless the bench goes looking. The directed preamble therefore builds such words deliberately, including an immediate whose upper bits name another register and an add with a nonzero shift field. Random traffic then mixes these cases with normal operations on register 0 and on wrapping values. After every instruction the debug port is pointed at the register the word could have written, and at the end every register is swept.

// File: rtl/sc_core_pkg.sv
`timescale 1ns/1ps
package sc_core_pkg;

    localparam int XLEN     = 32;
    localparam int REG_CNT  = 32;
    localparam int RIDX_W   = $clog2(REG_CNT);
    localparam int IMM_W    = 16;
    localparam int PC_STEP  = XLEN / 8;

    localparam logic [5:0] OPC_SPECIAL = 6'h00;
    localparam logic [5:0] OPC_ORI     = 6'h0D;
    localparam logic [5:0] FN_ADDU     = 6'h21;
    localparam logic [5:0] FN_SUBU     = 6'h23;

    typedef enum logic [1:0] {OP_NOP, OP_ADDU, OP_SUBU, OP_ORI} op_e;
    typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_OR}         alu_e;

    typedef struct packed {
        logic [5:0]        opc;
        logic [RIDX_W-1:0] rs;
        logic [RIDX_W-1:0] rt;
        logic [RIDX_W-1:0] rd;
        logic [4:0]        shamt;
        logic [5:0]        funct;
    } ifields_t;

    typedef struct packed {
        op_e  op;
        alu_e alu;
        logic use_imm;
        logic ext_sign;
        logic dst_rt;
        logic wr_en;
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(ifields_t f);
        ctrl_t c;
        c = '{op: OP_NOP, alu: ALU_ADD, use_imm: 1'b0,
              ext_sign: 1'b0, dst_rt: 1'b0, wr_en: 1'b0};
        if (f.opc == OPC_SPECIAL && f.shamt == 5'd0) begin
            if (f.funct == FN_ADDU) begin
                c.op = OP_ADDU; c.alu = ALU_ADD; c.wr_en = 1'b1;
            end else if (f.funct == FN_SUBU) begin
                c.op = OP_SUBU; c.alu = ALU_SUB; c.wr_en = 1'b1;
            end
        end else if (f.opc == OPC_ORI) begin
            c.op = OP_ORI; c.alu = ALU_OR; c.use_imm = 1'b1;
            c.ext_sign = 1'b0; c.dst_rt = 1'b1; c.wr_en = 1'b1;
        end
        return c;
    endfunction

    function automatic logic [XLEN-1:0] extend_imm(logic [IMM_W-1:0] imm, logic sgn);
        logic fill;
        fill = sgn & imm[IMM_W-1];
        return {{(XLEN-IMM_W){fill}}, imm};
    endfunction

endpackage

// File: rtl/sc_regfile.sv
`timescale 1ns/1ps
module sc_regfile #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32,
    parameter int N_RD   = 3,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [N_RD-1:0][ADDR_W-1:0]   raddr,
    output logic [N_RD-1:0][DATA_W-1:0]   rdata,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             waddr,
    input  logic [DATA_W-1:0]             wdata
);

    logic [DATA_W-1:0] regs [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < N_RD; g++) begin : g_rd
        assign rdata[g] = (raddr[g] == '0) ? '0 : regs[raddr[g]];
    end

    assert_r0_zero_R6: assert property (@(posedge clk) disable iff (rst)
        regs[0] == '0);

    assert_wr_lands_R8: assert property (@(posedge clk) disable iff (rst)
        (we && waddr != '0) |=> regs[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/sc_decoder.sv
`timescale 1ns/1ps
module sc_decoder
    import sc_core_pkg::*;
(
    input  ifields_t ins,
    output ctrl_t    ctrl
);
    always_comb ctrl = decode_ctrl(ins);
endmodule

// File: rtl/sc_alu.sv
`timescale 1ns/1ps
module sc_alu
    import sc_core_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_e         fn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (fn)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_OR:  y = a | b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/sc_core.sv
`timescale 1ns/1ps
module sc_core
    import sc_core_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [XLEN-1:0]   imem_addr,
    input  logic [XLEN-1:0]   imem_data,
    input  logic [RIDX_W-1:0] dbg_addr,
    output logic [XLEN-1:0]   dbg_data
);

    localparam int N_RD = 3;

    logic [XLEN-1:0]                 pc;
    ifields_t                        ins;
    ctrl_t                           ctrl;
    logic [N_RD-1:0][RIDX_W-1:0]     rf_raddr;
    logic [N_RD-1:0][XLEN-1:0]       rf_rdata;
    logic [XLEN-1:0]                 imm_ext, opnd_b, alu_y;
    logic [RIDX_W-1:0]               wr_idx;

    always_ff @(posedge clk) begin
        if (rst) pc <= '0;
        else     pc <= pc + XLEN'(PC_STEP);
    end
    assign imem_addr = pc;

    assign ins = ifields_t'(imem_data);

    sc_decoder u_dec (.ins(ins), .ctrl(ctrl));

    assign rf_raddr[0] = ins.rs;
    assign rf_raddr[1] = ins.rt;
    assign rf_raddr[2] = dbg_addr;

    sc_regfile #(.DATA_W(XLEN), .DEPTH(REG_CNT), .N_RD(N_RD)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .raddr (rf_raddr),
        .rdata (rf_rdata),
        .we    (ctrl.wr_en),
        .waddr (wr_idx),
        .wdata (alu_y)
    );

    assign imm_ext = extend_imm(imem_data[IMM_W-1:0], ctrl.ext_sign);
    assign opnd_b  = ctrl.use_imm ? imm_ext : rf_rdata[1];
    assign wr_idx  = ctrl.dst_rt ? ins.rt : ins.rd;

    sc_alu #(.W(XLEN)) u_alu (.fn(ctrl.alu), .a(rf_rdata[0]), .b(opnd_b), .y(alu_y));

    assign dbg_data = rf_rdata[2];

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> imem_addr == $past(imem_addr) + 32'd4);

    assert_rtype_dest_R3: assert property (@(posedge clk) disable iff (rst)
        (ctrl.wr_en && imem_data[31:26] == 6'h00) |-> wr_idx == imem_data[15:11]);

    assert_subu_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl.op == OP_SUBU) |-> (alu_y + rf_rdata[1]) == rf_rdata[0]);

    assert_ori_dest_R5: assert property (@(posedge clk) disable iff (rst)
        (imem_data[31:26] == 6'h0D) |-> (ctrl.wr_en && wr_idx == imem_data[20:16]
                                         && alu_y[31:16] == rf_rdata[0][31:16]));

    assert_nop_nowrite_R7: assert property (@(posedge clk) disable iff (rst)
        !(imem_data[31:26] == 6'h0D ||
          (imem_data[31:26] == 6'h00 && imem_data[10:6] == 5'd0 &&
           (imem_data[5:0] == 6'h21 || imem_data[5:0] == 6'h23))) |-> !ctrl.wr_en);

endmodule

// File: tb/sc_core_test.sv
`timescale 1ns/1ps
module sc_core_test;

    localparam int NPROG = 200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_data, dbg_data;
    logic [4:0]  dbg_addr = '0;

    logic [31:0] prog [256];
    logic [31:0] mr   [32];
    int          total = 0, bad = 0;
    bit          done  = 1'b0;

    always #2.5 clk = ~clk;

    sc_core uut (.clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
                 .dbg_addr(dbg_addr), .dbg_data(dbg_data));

    assign imem_data = prog[imem_addr[9:2]];

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    // expected register write of one word; returns 0 when no write
    function automatic bit model_exec(logic [31:0] w, output logic [4:0] dst,
                                      output logic [31:0] val, output string req);
        logic [31:0] a, b;
        a = mr[w[25:21]]; b = mr[w[20:16]];
        dst = w[20:16]; val = '0; req = "R7";
        if (w[31:26] == 6'h00 && w[10:6] == 5'd0 && w[5:0] == 6'h21) begin
            dst = w[15:11]; val = a + b; req = "R3"; return 1'b1;
        end
        if (w[31:26] == 6'h00 && w[10:6] == 5'd0 && w[5:0] == 6'h23) begin
            dst = w[15:11]; val = a - b; req = "R4"; return 1'b1;
        end
        if (w[31:26] == 6'h0D) begin
            val = a | {16'h0000, w[15:0]}; req = "R5"; return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        logic [5:0] junk_ops [4];
        junk_ops = '{6'h08, 6'h23, 6'h2B, 6'h04};
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) prog[i] = 32'h0;
        prog[0]  = enc_i(6'h0D, 0, 1, 16'h1234);
        prog[1]  = enc_i(6'h0D, 0, 2, 16'h8000);         // R5 zero extension of bit 15
        prog[2]  = enc_i(6'h0D, 1, 0, 16'hFFFF);         // R6 write to r0
        prog[3]  = enc_r(0, 1, 3, 0, 6'h23);             // R4 wrap below zero
        prog[4]  = enc_r(3, 3, 4, 0, 6'h21);             // R3 wrap past 2^32
        prog[5]  = enc_i(6'h0D, 0, 5, 16'hFFFF);
        prog[6]  = enc_r(1, 1, 1, 0, 6'h21);             // R8 dest equals source
        prog[7]  = enc_i(6'h08, 1, 1, 16'h0007);         // R7 unknown opcode
        prog[8]  = enc_r(1, 1, 2, 0, 6'h20);             // R7 unknown funct
        prog[9]  = enc_r(1, 1, 2, 1, 6'h21);             // R7 nonzero shift field
        prog[10] = enc_i(6'h0D, 0, 6, 16'h3800);         // R5 imm names r7 in rd field
        prog[11] = enc_r(1, 1, 0, 0, 6'h21);             // R6 add into r0
        prog[12] = enc_i(6'h0D, 5, 5, 16'h0001);         // R5 rt read value unused
        for (int i = 13; i < NPROG; i++) begin
            int k;
            k = int'($urandom_range(7, 0));
            if (k < 3)      prog[i] = enc_r($urandom_range(31,0), $urandom_range(31,0),
                                            $urandom_range(31,0), 0, 6'h21);
            else if (k < 5) prog[i] = enc_r($urandom_range(31,0), $urandom_range(31,0),
                                            $urandom_range(31,0), 0, 6'h23);
            else if (k < 7) prog[i] = enc_i(6'h0D, $urandom_range(31,0), $urandom_range(31,0),
                                            16'($urandom));
            else            prog[i] = enc_i(junk_ops[$urandom_range(3,0)],
                                            $urandom_range(31,0), $urandom_range(31,0),
                                            16'($urandom));
        end
        for (int r = 0; r < 32; r++) mr[r] = '0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 pc after reset", imem_addr, 32'h0);
        for (int r = 0; r < 32; r++) begin
            dbg_addr = 5'(r);
            #0.05;
            check("R1 register after reset", dbg_data, 32'h0);
        end

        for (int i = 0; i < NPROG; i++) begin
            logic [4:0]  dst;
            logic [31:0] val;
            string       req;
            bit          wr;
            wr = model_exec(prog[i], dst, val, req);
            if (wr && dst != 5'd0) mr[dst] = val;
            @(posedge clk);
            @(negedge clk);
            check("R2 pc step", imem_addr, 32'(4 * (i + 1)));
            dbg_addr = dst;
            #0.05;
            check(dst == 5'd0 ? "R6 r0 stays zero" : req, dbg_data, mr[dst]);
            if (i == 10) begin
                dbg_addr = 5'd7;      // R5: register named by imm[15:11] untouched
                #0.05;
                check("R5 rd field ignored", dbg_data, mr[7]);
            end
            if (i == 6) check("R8 old source value used", dbg_data, 32'h2468);
        end

        for (int r = 0; r < 32; r++) begin
            dbg_addr = 5'(r);         // R9 debug sweep
            #0.05;
            check("R9 final register", dbg_data, mr[r]);
        end
        finish_run();
    end

    initial begin
        #(200000 * 5);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

endmodule